// File: doc/BRIEF.md
# I2C Register Target with Per-Byte CRC-8

This block is an I2C target that gives a host controller access to a small bank of 8-bit registers. The host first writes a register pointer. It then either writes a run of data bytes, or starts a second address phase with the read bit set and reads a run of bytes back. The second address phase may follow a repeated START, or a STOP followed by a fresh START. The pointer advances after every data byte moved, wrapping from 0xFF to 0x00, so block transfers need no extra addressing.

When the `crc_en` input is high, every data byte on the bus is followed by a CRC-8 byte. The CRC uses polynomial 0x07, is processed MSB first, and starts from zero. The first data byte of a transaction is covered together with the address bytes that precede it in that address phase. Every later data byte is covered on its own. On writes the target checks the CRC and refuses a bad one. It does this by not acknowledging, dropping the byte, and going silent until the next START. On reads the target generates the CRC.

The bus lines are sampled through a synchroniser into a faster system clock. SDA is driven only as an open-drain pull-low enable. Clock stretching, general call and 10-bit addressing are not provided. A plain combinational read port lets on-chip logic observe the register contents. This port carries no handshake: it has no flow to throttle, and a value is always available in the same cycle.

Top module: `i2c_crc_regtarget`

## Requirements
- R1: The target acknowledges an address byte whose upper 7 bits equal `TGT_ADDR`. For any other address it never pulls SDA low, including the acknowledge slot and all later bytes, until the next START.
- R2: In a write, the byte after the address byte (LSB 0 = write) loads the register pointer. Each accepted data byte goes to the register at the pointer, and the pointer then increments.
- R3: SDA is sampled on SCL rising edges and the target changes SDA only after an SCL falling edge. A START (SDA falls while SCL high) restarts address reception from any state, including mid-byte. A STOP (SDA rises while SCL high) returns the target to idle.
- R4: With `crc_en` low, no CRC bytes are exchanged, and a written data byte is committed as soon as its acknowledge is driven.
- R5: With `crc_en` high, each written data byte is followed by a CRC byte. For the first data byte, the CRC covers the address byte, the pointer byte and the data byte. Each later data byte's CRC covers that byte alone. The CRC uses polynomial 0x07, MSB first, seed 0x00. The data byte is committed only once a matching CRC byte is acknowledged.
- R6: A CRC byte that does not match is not acknowledged. Its data byte is discarded and the target ignores the bus until the next START.
- R7: After a repeated START with the read bit (address LSB 1), the target sends the register at the pointer, then the following registers on each host ACK.
- R8: A read address phase that follows a STOP and a new START continues from the pointer left by the previous write.
- R9: With `crc_en` high, the target sends a CRC byte after each data byte it sends. The first covers the read address byte and the data byte; each later one covers its data byte alone.
- R10: A host NACK after a sent byte makes the target release SDA and stay idle until the next START.
- R11: The pointer wraps from 0xFF to 0x00. Addresses at or above `NREGS` read as 0x00, and writes to them change no register.
- R12: After reset every register holds 0x00 and SDA is released.
- R13: `app_rd_data` shows the register selected by `app_rd_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when high |
| crc_en | input | 1 | Enables the CRC byte after each data byte |
| app_rd_addr | input | 8 | On-chip register read address |
| app_rd_data | output | 8 | Register content at app_rd_addr (0x00 when unmapped) |

## Verification
The assertions check on every cycle that the target only begins pulling SDA low right after an SCL falling edge. They also check that START and STOP move the state from anywhere, that SDA is released whenever the target is idle, that no write commits with CRC enabled unless a CRC byte has just been checked, and that each commit advances the pointer. Only the directed scenarios can show the data-level behaviour. This covers the CRC values across the change of coverage after the first byte, refusal and discard of a bad CRC, pointer wrap and unmapped reads, and both read forms with the pointer carried across a STOP.

// File: rtl/i2c_crc_pkg.sv
package i2c_crc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_REG,
    ST_WDATA,
    ST_WCRC,
    ST_RDATA,
    ST_RCRC
  } tgt_state_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_lvl   = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/i2c_crc8_step.sv
module i2c_crc8_step #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic [7:0] seed,
  input  logic [7:0] data,
  output logic [7:0] result
);
  logic [7:0] acc;

  always_comb begin
    acc = seed ^ data;
    for (int i = 0; i < 8; i++) begin
      acc = acc[7] ? ((acc << 1) ^ POLY) : (acc << 1);
    end
    result = acc;
  end
endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank #(
  parameter int NREGS = 8,
  parameter int AW    = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr_a,
  output logic [DW-1:0] rd_data_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_b
);
  logic [DW-1:0] mem [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g] <= '0;
      end else if (wr_en && (wr_addr == AW'(g))) begin
        mem[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data_a = '0;
    rd_data_b = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (rd_addr_a == AW'(i)) rd_data_a = mem[i];
      if (rd_addr_b == AW'(i)) rd_data_b = mem[i];
    end
  end
endmodule

// File: rtl/i2c_crc_regtarget.sv
module i2c_crc_regtarget
  import i2c_crc_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'h2A,
  parameter int         NREGS       = 8,
  parameter logic [7:0] CRC_POLY    = 8'h07,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       crc_en,
  input  logic [7:0] app_rd_addr,
  output logic [7:0] app_rd_data
);
  localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);
  localparam logic [3:0] END_SLOT = 4'(BYTE_W + 1);

  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  tgt_state_e st;
  logic [3:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh, ptr, crc_acc, wbuf;
  logic [7:0] crc_seed, crc_data, crc_out, rd_byte;
  logic [7:0] wr_addr, wr_data;
  logic wr_en, rw_q, host_ack, sda_oe_q, is_tx;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_regbank #(.NREGS(NREGS), .AW(8), .DW(8)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr_a(ptr), .rd_data_a(rd_byte),
    .rd_addr_b(app_rd_addr), .rd_data_b(app_rd_data)
  );

  // One CRC step: received byte at the ack slot, register byte at load time
  assign crc_data = (bit_cnt == ACK_SLOT) ? rx_sh : rd_byte;
  assign crc_seed = (st == ST_ADDR && bit_cnt == ACK_SLOT) ? 8'h00 : crc_acc;

  i2c_crc8_step #(.POLY(CRC_POLY)) u_crc (
    .seed(crc_seed), .data(crc_data), .result(crc_out)
  );

  assign is_tx  = (st == ST_RDATA) || (st == ST_RCRC);
  assign sda_oe = sda_oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      ptr      <= '0;
      crc_acc  <= '0;
      wbuf     <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rw_q     <= 1'b0;
      host_ack <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st       <= ST_ADDR;
        bit_cnt  <= '0;
        sda_oe_q <= 1'b0;
      end else if (stop_det) begin
        st       <= ST_IDLE;
        bit_cnt  <= '0;
        sda_oe_q <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (bit_cnt < ACK_SLOT) rx_sh <= {rx_sh[6:0], sda_lvl};
          else if (bit_cnt == ACK_SLOT) host_ack <= ~sda_lvl;
          if (bit_cnt != END_SLOT) bit_cnt <= bit_cnt + 4'd1;
        end else if (scl_fall) begin
          if (is_tx && bit_cnt != 4'd0 && bit_cnt < ACK_SLOT) begin
            tx_sh    <= tx_sh << 1;
            sda_oe_q <= ~tx_sh[6];
          end else if (bit_cnt == ACK_SLOT) begin
            sda_oe_q <= 1'b0;
            unique case (st)
              ST_ADDR: begin
                if (rx_sh[7:1] == TGT_ADDR) begin
                  sda_oe_q <= 1'b1;
                  rw_q     <= rx_sh[0];
                  crc_acc  <= crc_out;
                end else begin
                  st <= ST_IDLE;
                end
              end
              ST_REG: begin
                sda_oe_q <= 1'b1;
                ptr      <= rx_sh;
                crc_acc  <= crc_out;
              end
              ST_WDATA: begin
                sda_oe_q <= 1'b1;
                if (crc_en) begin
                  wbuf    <= rx_sh;
                  crc_acc <= crc_out;
                end else begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= rx_sh;
                  ptr     <= ptr + 8'd1;
                end
              end
              ST_WCRC: begin
                if (rx_sh == crc_acc) begin
                  sda_oe_q <= 1'b1;
                  wr_en    <= 1'b1;
                  wr_addr  <= ptr;
                  wr_data  <= wbuf;
                  ptr      <= ptr + 8'd1;
                  crc_acc  <= 8'h00;
                end else begin
                  st <= ST_IDLE;
                end
              end
              default: ;
            endcase
          end else if (bit_cnt == END_SLOT) begin
            bit_cnt  <= '0;
            sda_oe_q <= 1'b0;
            unique case (st)
              ST_ADDR: begin
                if (rw_q) begin
                  st       <= ST_RDATA;
                  tx_sh    <= rd_byte;
                  sda_oe_q <= ~rd_byte[7];
                  crc_acc  <= crc_out;
                  ptr      <= ptr + 8'd1;
                end else begin
                  st <= ST_REG;
                end
              end
              ST_REG:   st <= ST_WDATA;
              ST_WDATA: st <= crc_en ? ST_WCRC : ST_WDATA;
              ST_WCRC:  st <= ST_WDATA;
              ST_RDATA: begin
                if (!host_ack) begin
                  st <= ST_IDLE;
                end else if (crc_en) begin
                  st       <= ST_RCRC;
                  tx_sh    <= crc_acc;
                  sda_oe_q <= ~crc_acc[7];
                  crc_acc  <= 8'h00;
                end else begin
                  tx_sh    <= rd_byte;
                  sda_oe_q <= ~rd_byte[7];
                  ptr      <= ptr + 8'd1;
                end
              end
              ST_RCRC: begin
                if (!host_ack) begin
                  st <= ST_IDLE;
                end else begin
                  st       <= ST_RDATA;
                  tx_sh    <= rd_byte;
                  sda_oe_q <= ~rd_byte[7];
                  crc_acc  <= crc_out;
                  ptr      <= ptr + 8'd1;
                end
              end
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_crc_regtarget_chk.sv
module i2c_crc_regtarget_chk
  import i2c_crc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input tgt_state_e st,
  input logic       sda_oe,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic [7:0] ptr,
  input logic       crc_en
);
  // R3: pulling SDA low begins only right after an SCL falling edge
  a_r3_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R3: START from any state restarts address reception
  a_r3_start_any_state: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_ADDR));

  // R3: STOP from any state returns to idle
  a_r3_stop_any_state: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE));

  // R1, R10: an idle target never holds SDA
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  // R6: with CRC on, a commit only follows a checked CRC byte
  a_r6_commit_after_crc: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && crc_en) |-> ($past(st) == ST_WCRC));

  // R2: every commit advances the pointer by one
  a_r2_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ptr == wr_addr + 8'd1));
endmodule

bind i2c_crc_regtarget i2c_crc_regtarget_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .sda_oe(sda_oe_q),
  .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
  .wr_en(wr_en), .wr_addr(wr_addr), .ptr(ptr), .crc_en(crc_en)
);

// File: tb/i2c_crc_regtarget_bench.sv
`timescale 1ns/1ps
module i2c_crc_regtarget_bench;
  localparam logic [6:0] ADDR = 7'h2A;
  localparam logic [7:0] AW_B = {ADDR, 1'b0};
  localparam logic [7:0] AR_B = {ADDR, 1'b1};
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic crc_en = 1'b0;
  logic [7:0] app_addr = 8'h00;
  logic [7:0] app_data;
  logic sda_oe;
  logic sda_line;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  assign sda_line = !(m_low || sda_oe);

  always #2.5 clk = ~clk;

  i2c_crc_regtarget u_i2c_crc_regtarget (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .crc_en(crc_en),
    .app_rd_addr(app_addr), .app_rd_data(app_data)
  );

  function automatic logic [7:0] crc8(input logic [7:0] seed, input logic [7:0] b);
    logic [7:0] c;
    c = seed ^ b;
    for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    return c;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_is(input string req, input logic [7:0] a, input logic [7:0] exp);
    app_addr = a;
    tick(1);
    chk(req, int'(app_data), int'(exp));
  endtask

  task automatic i2c_start();
    m_low = 1'b0; tick(Q);
    scl = 1'b1;   tick(2*Q);
    m_low = 1'b1; tick(2*Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; tick(Q);
    scl = 1'b1;   tick(2*Q);
    m_low = 1'b0; tick(2*Q);
  endtask

  task automatic send_bit(input bit b);
    m_low = !b; tick(Q);
    scl = 1'b1; tick(2*Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_low = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    ack = !sda_line;
    tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic rd_byte(input bit ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      scl = 1'b0;
    end
    tick(Q);
    m_low = ack;  tick(Q);
    scl = 1'b1;   tick(2*Q);
    scl = 1'b0;   tick(Q);
    m_low = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 sda released after reset", int'(sda_oe), 0);
    for (int a = 0; a < 8; a++) reg_is("R12/R13 register cleared", 8'(a), 8'h00);
  endtask

  task automatic t_wrong_addr();
    bit ack;
    i2c_start();
    wr_byte({7'h2B, 1'b0}, ack);
    chk("R1 foreign address not acked", int'(ack), 0);
    wr_byte(8'h02, ack);
    chk("R1 bus untouched after mismatch", int'(ack), 0);
    i2c_stop();
    reg_is("R1 no write after mismatch", 8'h02, 8'h00);
  endtask

  task automatic t_block_write();
    bit ack;
    crc_en = 1'b0;
    i2c_start();
    wr_byte(AW_B, ack);  chk("R1 own address acked", int'(ack), 1);
    wr_byte(8'h02, ack); chk("R2 pointer byte acked", int'(ack), 1);
    wr_byte(8'hA1, ack); chk("R4 data acked", int'(ack), 1);
    wr_byte(8'hB2, ack);
    wr_byte(8'hC3, ack); chk("R4 last data acked", int'(ack), 1);
    reg_is("R4 committed before STOP", 8'h04, 8'hC3);
    i2c_stop();
    reg_is("R2 block write reg2", 8'h02, 8'hA1);
    reg_is("R2 block write reg3", 8'h03, 8'hB2);
  endtask

  task automatic t_read_rs();
    bit ack;
    logic [7:0] b;
    i2c_start();
    wr_byte(AW_B, ack);
    wr_byte(8'h03, ack);
    i2c_start();
    wr_byte(AR_B, ack);  chk("R7 read address acked", int'(ack), 1);
    rd_byte(1'b1, b);    chk("R7 first read byte", int'(b), 8'hB2);
    rd_byte(1'b0, b);    chk("R7 incremented read byte", int'(b), 8'hC3);
    chk("R10 SDA released after NACK", int'(sda_oe), 0);
    rd_byte(1'b0, b);    chk("R10 idle after NACK", int'(b), 8'hFF);
    i2c_stop();
  endtask

  task automatic t_read_after_stop();
    bit ack;
    logic [7:0] b;
    i2c_start();
    wr_byte(AW_B, ack);
    wr_byte(8'h02, ack);
    i2c_stop();
    i2c_start();
    wr_byte(AR_B, ack);  chk("R8 read address acked", int'(ack), 1);
    rd_byte(1'b0, b);    chk("R8 pointer kept across STOP", int'(b), 8'hA1);
    i2c_stop();
  endtask

  task automatic t_write_crc();
    bit ack;
    logic [7:0] c;
    crc_en = 1'b1;
    i2c_start();
    wr_byte(AW_B, ack);
    wr_byte(8'h05, ack);
    wr_byte(8'h5A, ack); chk("R5 data acked", int'(ack), 1);
    reg_is("R5 no commit before CRC", 8'h05, 8'h00);
    c = crc8(crc8(crc8(8'h00, AW_B), 8'h05), 8'h5A);
    wr_byte(c, ack);     chk("R5 first CRC accepted", int'(ack), 1);
    reg_is("R5 first byte committed", 8'h05, 8'h5A);
    wr_byte(8'h3C, ack);
    wr_byte(crc8(8'h00, 8'h3C), ack);
    chk("R5 later CRC over byte alone", int'(ack), 1);
    i2c_stop();
    reg_is("R5 second byte committed", 8'h06, 8'h3C);
  endtask

  task automatic t_crc_bad();
    bit ack;
    logic [7:0] c;
    crc_en = 1'b1;
    i2c_start();
    wr_byte(AW_B, ack);
    wr_byte(8'h01, ack);
    wr_byte(8'h77, ack);
    c = crc8(crc8(crc8(8'h00, AW_B), 8'h01), 8'h77) ^ 8'h01;
    wr_byte(c, ack);     chk("R6 bad CRC NACKed", int'(ack), 0);
    wr_byte(8'h55, ack); chk("R6 idle after bad CRC", int'(ack), 0);
    i2c_stop();
    reg_is("R6 data discarded", 8'h01, 8'h00);
    i2c_start();
    wr_byte(AW_B, ack);  chk("R6 next START answered", int'(ack), 1);
    i2c_stop();
  endtask

  task automatic t_read_crc();
    bit ack;
    logic [7:0] b;
    crc_en = 1'b1;
    i2c_start();
    wr_byte(AW_B, ack);
    wr_byte(8'h05, ack);
    i2c_start();
    wr_byte(AR_B, ack);
    rd_byte(1'b1, b);  chk("R9 first data", int'(b), 8'h5A);
    rd_byte(1'b1, b);  chk("R9 first CRC with address", int'(b), int'(crc8(crc8(8'h00, AR_B), 8'h5A)));
    rd_byte(1'b1, b);  chk("R9 second data", int'(b), 8'h3C);
    rd_byte(1'b0, b);  chk("R9 second CRC byte alone", int'(b), int'(crc8(8'h00, 8'h3C)));
    i2c_stop();
    crc_en = 1'b0;
  endtask

  task automatic t_wrap();
    bit ack;
    logic [7:0] b;
    crc_en = 1'b0;
    i2c_start();
    wr_byte(AW_B, ack);
    wr_byte(8'hFF, ack);
    wr_byte(8'h11, ack);
    wr_byte(8'h22, ack);
    i2c_stop();
    reg_is("R11 pointer wrapped to 0", 8'h00, 8'h22);
    reg_is("R11 unmapped write ignored", 8'h07, 8'h00);
    i2c_start();
    wr_byte(AW_B, ack);
    wr_byte(8'hFE, ack);
    i2c_start();
    wr_byte(AR_B, ack);
    rd_byte(1'b1, b);  chk("R11 unmapped 0xFE reads 0", int'(b), 0);
    rd_byte(1'b1, b);  chk("R11 unmapped 0xFF reads 0", int'(b), 0);
    rd_byte(1'b0, b);  chk("R11 read wraps to 0x00", int'(b), 8'h22);
    i2c_stop();
  endtask

  task automatic t_restart_midbyte();
    bit ack;
    i2c_start();
    for (int i = 7; i >= 4; i--) send_bit(AW_B[i]);
    i2c_start();
    wr_byte(AW_B, ack);  chk("R3 START mid-byte restarts", int'(ack), 1);
    wr_byte(8'h07, ack);
    wr_byte(8'h99, ack);
    i2c_stop();
    reg_is("R3 write after mid-byte START", 8'h07, 8'h99);
  endtask

  initial begin
    tick(8);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_wrong_addr();
    t_block_write();
    t_read_rs();
    t_read_after_stop();
    t_write_crc();
    t_crc_bad();
    t_read_crc();
    t_wrap();
    t_restart_midbyte();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule